// File: doc/BRIEF.md
# Byte-Loaded Dual DAC Latch Front End

This block is the digital register front end of a two-channel converter whose 12-bit codes are fed from an 8-bit memory-mapped processor bus. Each channel has an input word built from two byte writes, a low byte and a high nibble, which may arrive in either order. The analog outputs follow a second rank of registers, the DAC latches, and not the input latches.

A transfer copies every channel's input word into its DAC latch on the same clock edge, so both outputs change together. A transfer can be started in two ways. A bus write to the load strobe starts one. A rising edge on an asynchronous load pin also starts one, and that pin may be wired to several such blocks. All bus signals are sampled in the system clock domain. A write is committed on the clock edge at which the sampled write strobe is seen returning high.

Top module: `dual_dac_byte_front`

## Requirements
- R1: While `rst_ni` is low, both DAC outputs read 0. After reset, a transfer with no prior writes also yields 0 on both outputs.
- R2: A write to address 0 (channel A) or 2 (channel B) stores all 8 data bits as bits 7:0 of that channel's input word. The DAC outputs do not change until a transfer.
- R3: A write to address 1 (channel A) or 3 (channel B) stores data bits 3:0 as bits 11:8 of the input word. Data bits 7:4 have no effect.
- R4: A write is committed at the first clock edge where `wr_ni` is sampled high after having been sampled low, provided `cs_ni` is low at that edge. With `cs_ni` high, the write changes nothing.
- R5: The high and low parts of a channel may be written in either order, and both orders give the same word.
- R6: A write strobe edge while `ld_sel_ni` is low copies both input words into both DAC latches on that same clock edge.
- R7: A rising edge of `ld_async_i` causes exactly one transfer, on the third clock edge that samples it high. Holding the pin high starts no further transfer.
- R8: When a byte write and a transfer occur on the same edge, the transfer moves the input word as it was before that write. The write still lands in the input latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low chip select for input-latch writes |
| wr_ni | input | 1 | Active-low write strobe; commit on its rising edge |
| ld_sel_ni | input | 1 | Active-low decoded load address strobe |
| addr_i | input | 2 | Half-latch select: bit 0 high/low, bit 1 channel |
| data_i | input | 8 | Bus data, right-justified |
| ld_async_i | input | 1 | Asynchronous load request, rising-edge triggered |
| dac_a_o | output | 12 | Channel A DAC latch |
| dac_b_o | output | 12 | Channel B DAC latch |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, 12-bit codes, two channels and a two-flop synchronizer. These values put both the 4-bit truncation of the high nibble and the three-edge latency of the asynchronous load path in reach. The bench drives the high nibble with bits 7:4 set, so a design that keeps those bits shows a wrong output. A load pulse held high for several cycles, and a write on the same edge as a load, test the one-transfer rule and the rule that a load takes the old contents.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;
  typedef enum logic {HALF_LO = 1'b0, HALF_HI = 1'b1} half_e;

  function automatic int hi_width(input int code_w, input int data_w);
    return code_w - data_w;
  endfunction
endpackage

// File: rtl/dac_bus_decode.sv
module dac_bus_decode #(
  parameter int NUM_CH = 2,
  localparam int NSEL = NUM_CH * 2,
  localparam int AW = $clog2(NSEL)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_ni,
  input  logic            wr_ni,
  input  logic            ld_sel_ni,
  input  logic [AW-1:0]   addr_i,
  output logic [NSEL-1:0] we_o,
  output logic            bus_load_o
);
  logic wr_q;
  logic wr_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b1;
    else         wr_q <= wr_ni;
  end

  assign wr_edge    = !wr_q && wr_ni;
  assign bus_load_o = wr_edge && !ld_sel_ni;

  always_comb begin
    we_o = '0;
    if (wr_edge && !cs_ni) we_o[addr_i] = 1'b1;
  end

  assert_we_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_o));
  assert_we_needs_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o != '0) |-> $past(!wr_ni));
endmodule

// File: rtl/dac_load_sync.sv
module dac_load_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign pulse_o = sync_q[STAGES-1] && !last_q;

  assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/dac_channel.sv
module dac_channel
  import dac_front_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 12,
  localparam int HI_W = hi_width(CODE_W, DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_lo_i,
  input  logic              we_hi_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] dac_o
);
  logic [DATA_W-1:0] in_lo_q;
  logic [HI_W-1:0]   in_hi_q;
  logic [CODE_W-1:0] dac_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_lo_q <= '0;
      in_hi_q <= '0;
      dac_q   <= '0;
    end else begin
      if (we_lo_i) in_lo_q <= data_i;
      if (we_hi_i) in_hi_q <= data_i[HI_W-1:0];  // right-justified nibble
      if (load_i)  dac_q   <= {in_hi_q, in_lo_q}; // pre-write contents
    end
  end

  assign dac_o = dac_q;

  assert_dac_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(dac_q));
  assert_load_copy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> dac_q == {$past(in_hi_q), $past(in_lo_q)});
  assert_lo_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_lo_i |=> $stable(in_lo_q));
endmodule

// File: rtl/dual_dac_byte_front.sv
module dual_dac_byte_front #(
  parameter int DATA_W      = 8,
  parameter int CODE_W      = 12,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_CH = 2,
  localparam int AW     = $clog2(NUM_CH * 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic              ld_sel_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ld_async_i,
  output logic [CODE_W-1:0] dac_a_o,
  output logic [CODE_W-1:0] dac_b_o
);
  logic [NUM_CH*2-1:0] we;
  logic                bus_load;
  logic                async_load;
  logic                load;
  logic [CODE_W-1:0]   dac [NUM_CH];

  dac_bus_decode #(.NUM_CH(NUM_CH)) u_decode (
    .clk_i, .rst_ni, .cs_ni, .wr_ni, .ld_sel_ni, .addr_i,
    .we_o(we), .bus_load_o(bus_load)
  );

  dac_load_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_i(ld_async_i), .pulse_o(async_load)
  );

  assign load = bus_load || async_load;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dac_channel #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_ch (
      .clk_i, .rst_ni,
      .we_lo_i(we[2*c]),
      .we_hi_i(we[2*c+1]),
      .load_i(load),
      .data_i,
      .dac_o(dac[c])
    );
  end

  assign dac_a_o = dac[0];
  assign dac_b_o = dac[1];

  assert_reset_zero_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (dac_a_o == '0 && dac_b_o == '0));
  assert_joint_update_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> ($stable(dac_a_o) && $stable(dac_b_o)));
endmodule

// File: tb/sim_dual_dac_byte_front.sv
module sim_dual_dac_byte_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1, ld_async = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] data = '0;
  logic [11:0] dac_a, dac_b;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;  // 125 MHz

  dual_dac_byte_front u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_ni(wr_n), .ld_sel_ni(ld_n),
    .addr_i(addr), .data_i(data), .ld_async_i(ld_async),
    .dac_a_o(dac_a), .dac_b_o(dac_b)
  );

  // behavioural reference
  int in_word[2];
  int out_word[2];
  int prev_wr = 1;
  int a_hist[$];
  int last_seen = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_word = '{0, 0}; out_word = '{0, 0}; prev_wr = 1; last_seen = 0;
      a_hist = '{0, 0};
    end else begin
      bit strobe, do_load;
      int ch, lvl;
      strobe = (prev_wr == 0) && (wr_n == 1'b1);
      lvl = a_hist[1];
      do_load = (strobe && !ld_n) || (lvl == 1 && last_seen == 0);
      if (do_load) begin out_word[0] = in_word[0]; out_word[1] = in_word[1]; end
      if (strobe && !cs_n) begin
        ch = addr[1];
        if (addr[0]) in_word[ch] = (in_word[ch] & 'hFF) | ((data & 'hF) << 8);
        else         in_word[ch] = (in_word[ch] & 'hF00) | data;
      end
      last_seen = lvl;
      a_hist.push_front(int'(ld_async));
      a_hist = a_hist[0:1];
      prev_wr = int'(wr_n);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R2 R6 R7 model A", int'(dac_a), out_word[0]);
    chk("R2 R6 R7 model B", int'(dac_b), out_word[1]);
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input bit cs, input bit ld);
    @(negedge clk); addr = a; data = d; cs_n = !cs; ld_n = !ld; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1; ld_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    idle(2);
    chk("R1 reset A", int'(dac_a), 0);
    chk("R1 reset B", int'(dac_b), 0);
    rst_n = 1'b1;
    bus_wr(2'b00, 8'h00, 0, 1);  // load only
    chk("R1 empty load", int'(dac_a), 0);
    // R2 / R3: low then high, nibble upper bits ignored
    bus_wr(2'b00, 8'hA5, 1, 0);
    bus_wr(2'b01, 8'hF3, 1, 0);
    chk("R2 no update before load", int'(dac_a), 0);
    bus_wr(2'b00, 8'h00, 0, 1);
    chk("R3 A word", int'(dac_a), 'h3A5);
    // R5: high then low on channel B
    bus_wr(2'b11, 8'hEC, 1, 0);
    bus_wr(2'b10, 8'h5A, 1, 0);
    bus_wr(2'b00, 8'h00, 0, 1);
    chk("R5 B word", int'(dac_b), 'hC5A);
    chk("R6 A kept", int'(dac_a), 'h3A5);
    // R4: cs high ignored
    bus_wr(2'b00, 8'h11, 0, 0);
    bus_wr(2'b00, 8'h00, 0, 1);
    chk("R4 cs gate", int'(dac_a), 'h3A5);
    // R4: strobe held low commits nothing
    @(negedge clk); cs_n = 1'b0; addr = 2'b10; data = 8'h77; wr_n = 1'b0;
    idle(3); cs_n = 1'b1; data = 8'h00;
    @(negedge clk); wr_n = 1'b1;
    idle(1);
    bus_wr(2'b00, 8'h00, 0, 1);
    chk("R4 edge only", int'(dac_b), 'hC5A);
    // R8: write + load same edge
    bus_wr(2'b01, 8'h07, 1, 1);
    chk("R8 old contents", int'(dac_a), 'h3A5);
    bus_wr(2'b00, 8'h00, 0, 1);
    chk("R8 write landed", int'(dac_a), 'h7A5);
    // R7: async load, held high
    bus_wr(2'b10, 8'h99, 1, 0);
    @(negedge clk); ld_async = 1'b1;
    idle(2);
    chk("R7 not yet", int'(dac_b), 'hC5A);
    idle(1);
    chk("R7 transfer", int'(dac_b), 'hC99);
    bus_wr(2'b11, 8'h01, 1, 0);
    idle(4);
    chk("R7 single", int'(dac_b), 'hC99);
    @(negedge clk); ld_async = 1'b0;
    idle(4);
    chk("R7 no fall load", int'(dac_b), 'hC99);
    @(negedge clk); ld_async = 1'b1;
    idle(4);
    chk("R7 second edge", int'(dac_b), 'h199);
    ld_async = 1'b0;
    idle(4);
    report();
  end
endmodule